// File: doc/BRIEF.md
# Stereo Serial Audio Port (Slave, Two Framings)

This block is the digital serial side of a stereo codec working as a bit-clock slave. An external master drives the bit clock and the channel (word-select) clock. The port takes 20-bit converter samples from a parallel stream and shifts them out on the serial data output. It also collects playback samples from the serial data input and delivers them as a parallel stream. All three serial inputs are oversampled by the block's own system clock through a synchronizer, so every register runs on `clk`. The bit clock must be at most a quarter of the system clock rate.

A static format input selects one of two framings. Format 0 sends the 20-bit word MSB-first starting in the first bit slot of a channel. In the same format it receives a 24-bit word whose LSB lands in the last of the 32 slots of that channel. Format 1 uses 20-bit words in both directions, with the MSB delayed by one bit slot after the channel change. Received words always leave left-aligned in a 24-bit field.

Transmit samples enter as a stereo pair with valid/ready. The pair is held in one staging register, and the staging register is emptied at the start of the left channel. Received words leave with valid/ready and a single holding register. A serial stream cannot stall, so a word still unaccepted when the next channel completes is replaced by the newer word.

Top module: `stereo_serial_port`

## Requirements
- R1: After reset `sdto` is low, `tx_ready` is high and `rx_valid` is low. No bit is sent and no word is received until the first change of `lrck` seen at a falling `bclk` edge. The first falling edge after reset only records the `lrck` level.
- R2: With `fmt_sel`=0 the left channel is `lrck` high; with `fmt_sel`=1 it is `lrck` low. A channel begins at the first falling `bclk` edge at which `lrck` differs from its previous level. That bit period is slot 0, and each later falling edge advances the slot by one (32 slots per channel).
- R3: With `fmt_sel`=0, transmit bit 19 is in slot 0 and bit 0 is in slot 19. Slots 20 to 31 are driven low.
- R4: With `fmt_sel`=1, slot 0 is low, bit 19 is in slot 1 and bit 0 is in slot 20. Slots 21 to 31 are driven low.
- R5: `sdto` changes only in the cycle after a detected falling `bclk` edge, so it is steady at every rising `bclk` edge. `sdti` is sampled at rising `bclk` edges.
- R6: With `fmt_sel`=0, `sdti` bit 23 is taken from slot 8 and bit 0 from slot 31. Slots 0 to 7 are ignored, and the 24-bit word appears unchanged on `rx_data`.
- R7: With `fmt_sel`=1, `sdti` bits 19 to 0 are taken from slots 1 to 20 and all other slots are ignored. `rx_data` is the word shifted left by 4, so its low four bits are zero.
- R8: Every completed channel yields exactly one received word, with `rx_left`=1 for the left channel. `rx_valid` rises only in the cycle after a detected rising `bclk` edge.
- R9: `rx_valid` stays high until `rx_ready` is seen high. A word completed while the previous one is unaccepted overwrites it.
- R10: `tx_ready` is high when the staging register is empty and goes low the cycle after a pair is accepted. The staged pair is taken at the next left-channel start: its left word goes out in that channel and its right word in the following right channel. A pair accepted while a frame is in flight does not change the words being sent.
- R11: If no pair is staged when a left channel starts, both channels of that frame transmit all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 1 | Static framing select (0: edge-aligned out / 24-bit right-justified in; 1: delayed 20-bit both ways) |
| bclk | input | 1 | Serial bit clock from the master |
| lrck | input | 1 | Channel select clock from the master |
| sdti | input | 1 | Serial playback data in |
| sdto | output | 1 | Serial capture data out |
| tx_valid | input | 1 | Transmit pair valid |
| tx_ready | output | 1 | Staging register empty |
| tx_left | input | 20 | Left transmit sample |
| tx_right | input | 20 | Right transmit sample |
| rx_valid | output | 1 | Received word valid |
| rx_ready | input | 1 | Consumer accepts received word |
| rx_data | output | 24 | Received word, left-aligned |
| rx_left | output | 1 | Received word belongs to left channel |

## Verification
The bench builds the port with its default parameters: 32 slots per channel, a 20-bit transmit word, a 24-bit wide receive word and two synchronizer stages. It runs the bit clock at one eighth of the system clock. In each format, 24 frames walk a single one and a single zero through every transmit bit position of both channels. The same frames walk a single one through every receive bit position, while the don't-care slots carry noise that must not leak into the words. A skipped transmit pair reaches the zero-fill case, and a frame with the consumer stalled reaches the overwrite rule.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    FMT_EDGE    = 1'b0,
    FMT_DELAYED = 1'b1
  } fmt_e;
endpackage

// File: rtl/ssp_sync.sv
// Multi-bit synchronizer for the externally clocked serial lines.
module ssp_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ssp_frame_timer.sv
// Edge detection, channel boundary detection and slot counting.
module ssp_frame_timer
  import ssp_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt,
  input  logic          bclk_s,
  input  logic          lrck_s,
  output logic          bclk_fall,
  output logic          bclk_rise,
  output logic          boundary,
  output logic          new_left,
  output logic [SW-1:0] slot,
  output logic          chan_left,
  output logic          locked
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  logic bclk_d, lrck_ref, have_ref;

  assign bclk_fall = bclk_d & ~bclk_s;
  assign bclk_rise = ~bclk_d & bclk_s;
  assign boundary  = bclk_fall & have_ref & (lrck_s != lrck_ref);
  // left is lrck high in the edge format, lrck low in the delayed format
  assign new_left  = lrck_s ^ (fmt == FMT_DELAYED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d    <= 1'b0;
      lrck_ref  <= 1'b0;
      have_ref  <= 1'b0;
      slot      <= '0;
      chan_left <= 1'b0;
      locked    <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      if (bclk_fall) begin
        have_ref <= 1'b1;
        lrck_ref <= lrck_s;
        if (boundary) begin
          slot      <= '0;
          chan_left <= new_left;
          locked    <= 1'b1;
        end else if (slot != LAST_SLOT) begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_tx.sv
// Transmit staging and serializer.
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fmt_e         fmt,
  input  logic         bclk_fall,
  input  logic         boundary,
  input  logic         new_left,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic         sdto
);
  logic [W-1:0] stage_l, stage_r, hold_r, sh, load_word;
  logic         stage_full;

  assign tx_ready = ~stage_full;

  always_comb begin
    if (new_left) load_word = stage_full ? stage_l : '0;
    else          load_word = hold_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_l    <= '0;
      stage_r    <= '0;
      stage_full <= 1'b0;
      hold_r     <= '0;
      sh         <= '0;
      sdto       <= 1'b0;
    end else begin
      if (boundary && new_left) begin
        hold_r     <= stage_full ? stage_r : '0;
        stage_full <= 1'b0;
      end
      if (bclk_fall) begin
        if (boundary) begin
          if (fmt == FMT_DELAYED) begin
            sdto <= 1'b0;
            sh   <= load_word;
          end else begin
            sdto <= load_word[W-1];
            sh   <= {load_word[W-2:0], 1'b0};
          end
        end else begin
          sdto <= sh[W-1];
          sh   <= {sh[W-2:0], 1'b0};
        end
      end
      // placed last: a pair arriving at the left start waits for the next frame
      if (tx_valid && tx_ready) begin
        stage_l    <= tx_left;
        stage_r    <= tx_right;
        stage_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssp_rx.sv
// Receive deserializer with a single overwriting holding register.
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int SW    = $clog2(SLOTS),
  parameter int WN    = 20,
  parameter int WW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt,
  input  logic          bclk_rise,
  input  logic          boundary,
  input  logic          locked,
  input  logic [SW-1:0] slot,
  input  logic          chan_left,
  input  logic          sdti_s,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [WW-1:0] rx_data,
  output logic          rx_left
);
  localparam logic [SW-1:0] WIDE_FIRST  = SW'(SLOTS - WW);
  localparam logic [SW-1:0] WIDE_LAST   = SW'(SLOTS - 1);
  localparam logic [SW-1:0] NARROW_LAST = SW'(WN);
  localparam logic [SW-1:0] SLOT_ONE    = SW'(1);

  logic [WW-1:0] sh, shifted;
  logic          done, in_win, at_last, take, complete;

  always_comb begin
    if (fmt == FMT_DELAYED) begin
      in_win  = (slot >= SLOT_ONE) && (slot <= NARROW_LAST);
      at_last = (slot == NARROW_LAST);
    end else begin
      in_win  = (slot >= WIDE_FIRST);
      at_last = (slot == WIDE_LAST);
    end
  end

  assign shifted  = {sh[WW-2:0], sdti_s};
  assign take     = bclk_rise & locked & ~done & in_win;
  assign complete = take & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_left  <= 1'b0;
    end else begin
      if (boundary) done <= 1'b0;
      if (take) sh <= shifted;
      if (complete) begin
        done     <= 1'b1;
        rx_valid <= 1'b1;
        rx_left  <= chan_left;
        if (fmt == FMT_DELAYED) rx_data <= {shifted[WN-1:0], {(WW-WN){1'b0}}};
        else                    rx_data <= shifted;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stereo_serial_port.sv
module stereo_serial_port
  import ssp_pkg::*;
#(
  parameter int SLOTS       = 32,
  parameter int TX_W        = 20,
  parameter int RX_W        = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fmt_sel,
  input  logic            bclk,
  input  logic            lrck,
  input  logic            sdti,
  output logic            sdto,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [TX_W-1:0] tx_left,
  input  logic [TX_W-1:0] tx_right,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [RX_W-1:0] rx_data,
  output logic            rx_left
);
  localparam int SW = $clog2(SLOTS);

  fmt_e          fmt;
  logic          bclk_s, lrck_s, sdti_s;
  logic          bclk_fall, bclk_rise, boundary, new_left, chan_left, locked;
  logic [SW-1:0] slot;

  assign fmt = fmt_e'(fmt_sel);

  ssp_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sdti, lrck, bclk}),
    .q     ({sdti_s, lrck_s, bclk_s})
  );

  ssp_frame_timer #(.SLOTS(SLOTS), .SW(SW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .bclk_s    (bclk_s),
    .lrck_s    (lrck_s),
    .bclk_fall (bclk_fall),
    .bclk_rise (bclk_rise),
    .boundary  (boundary),
    .new_left  (new_left),
    .slot      (slot),
    .chan_left (chan_left),
    .locked    (locked)
  );

  ssp_tx #(.W(TX_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .bclk_fall (bclk_fall),
    .boundary  (boundary),
    .new_left  (new_left),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_left   (tx_left),
    .tx_right  (tx_right),
    .sdto      (sdto)
  );

  ssp_rx #(.SLOTS(SLOTS), .SW(SW), .WN(TX_W), .WW(RX_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .bclk_rise (bclk_rise),
    .boundary  (boundary),
    .locked    (locked),
    .slot      (slot),
    .chan_left (chan_left),
    .sdti_s    (sdti_s),
    .rx_ready  (rx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_left   (rx_left)
  );
endmodule

// File: rtl/stereo_serial_port_chk.sv
module stereo_serial_port_chk #(
  parameter int RX_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fmt_sel,
  input logic            sdto,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [RX_W-1:0] rx_data,
  input logic            bclk_fall,
  input logic            bclk_rise,
  input logic            boundary,
  input logic            locked
);
  AST_IDLE_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!sdto && !rx_valid)); // R1

  AST_DELAYED_SLOT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(boundary) && fmt_sel) |-> !sdto); // R4

  AST_SDTO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdto) |-> $past(bclk_fall)); // R5

  AST_RX_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fmt_sel) |-> (rx_data[3:0] == 4'h0)); // R7

  AST_RX_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(bclk_rise)); // R8

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid); // R9

  AST_TX_STAGE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R10
endmodule

bind stereo_serial_port stereo_serial_port_chk #(.RX_W(RX_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_sel   (fmt_sel),
  .sdto      (sdto),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .bclk_fall (bclk_fall),
  .bclk_rise (bclk_rise),
  .boundary  (boundary),
  .locked    (locked)
);

// File: tb/test_stereo_serial_port.sv
`timescale 1ns/1ps
module test_stereo_serial_port;
  localparam int NF = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_sel = 1'b0;
  logic        bclk = 1'b1;
  logic        lrck = 1'b0;
  logic        sdti = 1'b0;
  logic        sdto;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [19:0] tx_left = '0;
  logic [19:0] tx_right = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [23:0] rx_data;
  logic        rx_left;

  int n_chk = 0;
  int n_fail = 0;
  int n_got = 0;
  int n_exp = 0;
  logic [23:0] got_d [128];
  logic        got_l [128];
  logic [23:0] exp_d [128];
  logic        exp_l [128];

  always #4 clk = ~clk;

  stereo_serial_port i_stereo_serial_port (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk(bclk), .lrck(lrck),
    .sdti(sdti), .sdto(sdto), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_left(tx_left), .tx_right(tx_right), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_left(rx_left)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready && n_got < 128) begin
      got_d[n_got] = rx_data;
      got_l[n_got] = rx_left;
      n_got++;
    end
  end

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary_and_end();
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] txw(input int f, input int ch);
    logic [19:0] w;
    if (f < 20)       w = 20'h1 << f;
    else if (f == 20) w = 20'hFFFFF;
    else if (f == 21) w = 20'h00000;
    else if (f == 22) w = 20'hAAAAA;
    else              w = 20'h5A5A5;
    return (ch == 0) ? w : ~w;
  endfunction

  function automatic logic [23:0] rxw(input int f, input int ch);
    logic [23:0] w;
    w = 24'h1 << f;
    return (ch == 0) ? w : ~w;
  endfunction

  // one bit period: falling edge, low half, rising edge, high half
  task automatic run_slot(input logic lr, input logic di,
                          output logic early, output logic late);
    @(negedge clk);
    bclk = 1'b0; lrck = lr; sdti = di;
    repeat (3) @(negedge clk);
    early = sdto;
    @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
    late = sdto;
  endtask

  task automatic push(input logic [19:0] l, input logic [19:0] r);
    @(negedge clk);
    chk("R10", "tx_ready before push", {31'd0, tx_ready}, 32'd1);
    tx_valid = 1'b1; tx_left = l; tx_right = r;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R10", "tx_ready after accept", {31'd0, tx_ready}, 32'd0);
  endtask

  task automatic run_frame(input int fmt, input int f, input logic left_lvl);
    for (int ch = 0; ch < 2; ch++) begin
      logic [31:0] got_v, exp_v;
      logic        steady, early, late, di, eb;
      logic [19:0] tw;
      logic [23:0] rw;
      got_v = '0; exp_v = '0; steady = 1'b1;
      tw = (f == 11) ? 20'h0 : txw(f, ch);
      rw = rxw(f, ch);
      for (int s = 0; s < 32; s++) begin
        di = (((s * 5 + f * 3 + ch * 7) % 4) < 2);
        if (fmt == 0) begin
          if (s >= 8) di = rw[31 - s];
          eb = (s < 20) ? tw[19 - s] : 1'b0;
        end else begin
          if (s >= 1 && s <= 20) di = rw[20 - s];
          eb = (s >= 1 && s <= 20) ? tw[20 - s] : 1'b0;
        end
        run_slot((ch == 0) ? left_lvl : ~left_lvl, di, early, late);
        got_v = {got_v[30:0], late};
        exp_v = {exp_v[30:0], eb};
        if (early !== late) steady = 1'b0;
        if (ch == 1 && s == 2 && f != 10 && f + 1 < NF)
          push(txw(f + 1, 0), txw(f + 1, 1));
      end
      if (fmt == 0) chk((f == 11) ? "R11" : "R3", (ch == 0) ? "R2 left slots" : "R2 right slots", got_v, exp_v);
      else          chk((f == 11) ? "R11" : "R4", (ch == 0) ? "R2 left slots" : "R2 right slots", got_v, exp_v);
      chk("R5", "sdto steady across rising edge", {31'd0, steady}, 32'd1);
      if (!(fmt == 1 && f == 5 && ch == 0)) begin
        exp_d[n_exp] = (fmt == 0) ? rw : {rw[19:0], 4'h0};
        exp_l[n_exp] = (ch == 0);
        n_exp++;
      end
    end
  endtask

  initial begin
    for (int fmt = 0; fmt < 2; fmt++) begin
      logic left_lvl, e, l;
      left_lvl = (fmt == 0);
      rst_n = 1'b0; fmt_sel = fmt[0]; bclk = 1'b1; lrck = ~left_lvl;
      rx_ready = 1'b1; n_got = 0; n_exp = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "sdto after reset", {31'd0, sdto}, 32'd0);
      chk("R1", "tx_ready after reset", {31'd0, tx_ready}, 32'd1);
      chk("R1", "rx_valid after reset", {31'd0, rx_valid}, 32'd0);
      push(txw(0, 0), txw(0, 1));
      for (int s = 0; s < 4; s++) begin
        run_slot(~left_lvl, s[0], e, l);
        chk("R1", "sdto before lock", {31'd0, l}, 32'd0);
      end
      chk("R1", "no rx word before lock", n_got, 32'd0);
      for (int f = 0; f < NF; f++) begin
        if (fmt == 1 && f == 5) rx_ready = 1'b0;
        run_frame(fmt, f, left_lvl);
        if (fmt == 1 && f == 5) begin
          chk("R9", "rx_valid held", {31'd0, rx_valid}, 32'd1);
          chk("R9", "overwritten word", {8'd0, rx_data}, {8'd0, rxw(5, 1)[19:0], 4'h0});
          chk("R9", "overwritten word channel", {31'd0, rx_left}, 32'd0);
          rx_ready = 1'b1;
          repeat (2) @(negedge clk);
        end
      end
      repeat (8) @(negedge clk);
      chk("R8", "received word count", n_got, n_exp);
      for (int i = 0; i < n_exp && i < n_got; i++) begin
        chk((fmt == 0) ? "R6" : "R7", "rx word", {8'd0, got_d[i]}, {8'd0, exp_d[i]});
        chk("R8", "rx channel flag", {31'd0, got_l[i]}, {31'd0, exp_l[i]});
      end
    end
    summary_and_end();
  end
endmodule